// File: doc/BRIEF.md
# Reservation Monitor for Conditional Stores

This block keeps the address reservations behind load-reserved / store-conditional atomic pairs for several hardware contexts that share one memory. Each context owns one reservation: a physical address and a valid flag. Every context presents one request per cycle: a valid strobe, read or write, a locked qualifier, an uncacheable qualifier and an address. The block answers every store with a result code and a write enable that the memory path uses to gate the actual write.

A locked load opens a reservation. A locked store is a conditional store. It succeeds only while its context still holds a reservation on the same aligned granule, which is `2**GRAN_BITS` bytes wide and 16 bytes by default. Every store that is allowed to reach memory is broadcast to all contexts. It cancels any reservation on its granule, including the reservation of the context that issued it. A conditional store to uncacheable space always writes and reports a separate code. Each context also counts its conditional-store failures in a row and raises a warning pulse at each multiple of `WARN_PERIOD`, so that a livelocked retry loop can be seen.

Top module: `resv_monitor`

## Requirements
- R1: A locked load (valid=1, write=0, locked=1) sets its context's reservation flag and records its address, unless R7 applies.
- R2: A cacheable conditional store (valid=1, write=1, locked=1, uncacheable=0) whose context holds a set flag on the same granule returns code 1 (pass) with the write enable high.
- R3: A cacheable conditional store returns code 0 (fail) with the write enable low when the flag is clear, or when the store address and the reserved address differ in any bit at or above bit GRAN_BITS.
- R4: A failed conditional store clears the reservation flag of its own context.
- R5: An uncacheable conditional store returns code 2 with the write enable high, whatever the reservation state, and resets the context's failure run to zero.
- R6: A plain store (valid=1, write=1, locked=0) returns code 1 with the write enable high. Every committed store (a plain store, a passing store or an uncacheable conditional store) clears the flag of every context whose reserved granule equals the store's granule, the issuer included.
- R7: When a locked load and a committed store to the same granule arrive in the same cycle, the store wins and the load leaves its context's flag clear.
- R8: Each context counts consecutive failed conditional stores. A pass or an uncacheable conditional store resets the count. `fail_warn` pulses together with the failing response each time the count reaches a multiple of WARN_PERIOD.
- R9: Responses are registered. `rsp_valid`, `rsp_code` and `rsp_wr_en` appear one clock after the store request. Loads and idle cycles produce no response.
- R10: Synchronous active-high reset clears all flags and failure counts and leaves every response output low.

Field layout: context i uses bit i of each one-bit vector, `req_addr[i*ADDR_W +: ADDR_W]` and `rsp_code[2*i +: 2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_CTX | Request present, one bit per context |
| req_write | input | NUM_CTX | 1 = store, 0 = load |
| req_locked | input | NUM_CTX | Load-reserved or conditional-store qualifier |
| req_uncache | input | NUM_CTX | Target is uncacheable |
| req_addr | input | NUM_CTX*ADDR_W | Physical address per context |
| rsp_valid | output | NUM_CTX | Store response strobe |
| rsp_code | output | 2*NUM_CTX | 0 fail, 1 pass, 2 uncacheable |
| rsp_wr_en | output | NUM_CTX | Memory write permitted |
| fail_warn | output | NUM_CTX | Failure-run warning pulse |

## Verification
The bound checker checks the following on every cycle. A store always gets its response one cycle later. A store with no reservation behind it never writes. Uncacheable conditional stores always report code 2 and write. A locked load with no store traffic leaves a valid reservation on its address. A plain store from any context cancels a matching reservation in any other context. A load that collides with such a store never leaves a reservation. A warning never appears without a failing response. Whether the failure count reaches the right multiple, and whether it restarts after a pass, an uncacheable store or a reset, is visible only over a sequence of requests, so only the bench's scenarios show it. The same holds for the clearing of the issuer's own reservation after its own pass or fail, and for clearing done by conditional stores of other contexts.

// File: rtl/resv_pkg.sv
package resv_pkg;
   typedef enum logic [1:0] {
      RC_FAIL     = 2'd0,
      RC_PASS     = 2'd1,
      RC_UNCACHED = 2'd2
   } resv_code_e;
endpackage

// File: rtl/resv_store_eval.sv
// Per-context request decode: decides the response code and whether the
// store commits, against the reservation as it stands this cycle.
module resv_store_eval
   import resv_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int GRAN_BITS = 4
) (
   input  logic              valid,
   input  logic              write,
   input  logic              locked,
   input  logic              uncache,
   input  logic [ADDR_W-1:0] addr,
   input  logic              cur_flag,
   input  logic [ADDR_W-1:0] cur_addr,
   output logic              is_store,
   output logic              commit,
   output logic              sc_fail,
   output logic              cnt_clr,
   output logic              load_set,
   output resv_code_e        code
);
   logic gran_eq;
   assign gran_eq  = (addr[ADDR_W-1:GRAN_BITS] == cur_addr[ADDR_W-1:GRAN_BITS]);
   assign is_store = valid & write;
   assign load_set = valid & ~write & locked;

   always_comb begin
      commit  = 1'b0;
      sc_fail = 1'b0;
      cnt_clr = 1'b0;
      code    = RC_FAIL;
      if (is_store) begin
         if (!locked) begin
            commit = 1'b1;
            code   = RC_PASS;
         end else if (uncache) begin
            commit  = 1'b1;
            cnt_clr = 1'b1;
            code    = RC_UNCACHED;
         end else if (cur_flag && gran_eq) begin
            commit  = 1'b1;
            cnt_clr = 1'b1;
            code    = RC_PASS;
         end else begin
            sc_fail = 1'b1;
         end
      end
   end
endmodule

// File: rtl/resv_snoop.sv
// Compares the committed-store broadcast against one context's reserved
// granule and against the granule of its incoming locked load.
module resv_snoop #(
   parameter int NUM_CTX = 4,
   parameter int TAG_W   = 28
) (
   input  logic [NUM_CTX-1:0]       commit,
   input  logic [NUM_CTX*TAG_W-1:0] commit_tag,
   input  logic [TAG_W-1:0]         own_tag,
   input  logic [TAG_W-1:0]         load_tag,
   output logic                     hit_own,
   output logic                     hit_load
);
   always_comb begin
      hit_own  = 1'b0;
      hit_load = 1'b0;
      for (int k = 0; k < NUM_CTX; k++) begin
         if (commit[k] && commit_tag[k*TAG_W +: TAG_W] == own_tag)  hit_own  = 1'b1;
         if (commit[k] && commit_tag[k*TAG_W +: TAG_W] == load_tag) hit_load = 1'b1;
      end
   end
endmodule

// File: rtl/resv_slot.sv
// One context's reservation register, failure-run counter and
// registered response.
module resv_slot
   import resv_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int WARN_PERIOD = 100000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_set,
   input  logic              load_blocked,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              clear_hit,
   input  logic              is_store,
   input  logic              commit,
   input  logic              sc_fail,
   input  logic              cnt_clr,
   input  resv_code_e        code,
   output logic              flag,
   output logic [ADDR_W-1:0] addr,
   output logic              rsp_valid,
   output logic [1:0]        rsp_code,
   output logic              rsp_wr_en,
   output logic              warn
);
   localparam int CNT_W = $clog2(WARN_PERIOD + 1);
   localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(WARN_PERIOD - 1);

   logic [CNT_W-1:0] fail_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         flag      <= 1'b0;
         addr      <= '0;
         fail_run  <= '0;
         rsp_valid <= 1'b0;
         rsp_code  <= RC_FAIL;
         rsp_wr_en <= 1'b0;
         warn      <= 1'b0;
      end else begin
         rsp_valid <= is_store;
         rsp_code  <= code;
         rsp_wr_en <= commit;
         warn      <= 1'b0;
         if (load_set) begin
            flag <= ~load_blocked;
            addr <= load_addr;
         end else if (sc_fail || clear_hit) begin
            flag <= 1'b0;
         end
         if (cnt_clr) begin
            fail_run <= '0;
         end else if (sc_fail) begin
            if (fail_run == RUN_LAST) begin
               fail_run <= '0;
               warn     <= 1'b1;
            end else begin
               fail_run <= fail_run + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
   import resv_pkg::*;
#(
   parameter int NUM_CTX     = 4,
   parameter int ADDR_W      = 32,
   parameter int GRAN_BITS   = 4,
   parameter int WARN_PERIOD = 100000
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [NUM_CTX-1:0]        req_valid,
   input  logic [NUM_CTX-1:0]        req_write,
   input  logic [NUM_CTX-1:0]        req_locked,
   input  logic [NUM_CTX-1:0]        req_uncache,
   input  logic [NUM_CTX*ADDR_W-1:0] req_addr,
   output logic [NUM_CTX-1:0]        rsp_valid,
   output logic [2*NUM_CTX-1:0]      rsp_code,
   output logic [NUM_CTX-1:0]        rsp_wr_en,
   output logic [NUM_CTX-1:0]        fail_warn
);
   localparam int TAG_W = ADDR_W - GRAN_BITS;

   if (NUM_CTX < 1)          begin : g_bad_ctx  $error("NUM_CTX must be at least 1");        end
   if (GRAN_BITS < 0)        begin : g_bad_gran $error("GRAN_BITS must not be negative");     end
   if (GRAN_BITS >= ADDR_W)  begin : g_bad_addr $error("ADDR_W must exceed GRAN_BITS");       end
   if (WARN_PERIOD < 1)      begin : g_bad_warn $error("WARN_PERIOD must be at least 1");     end

   logic [NUM_CTX-1:0]        resv_flag;
   logic [NUM_CTX*ADDR_W-1:0] resv_addr;
   logic [NUM_CTX-1:0]        commit;
   logic [NUM_CTX*TAG_W-1:0]  commit_tag;

   for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
      logic       is_store, sc_fail, cnt_clr, load_set;
      logic       hit_own, hit_load;
      resv_code_e code;

      assign commit_tag[i*TAG_W +: TAG_W] = req_addr[i*ADDR_W+GRAN_BITS +: TAG_W];

      resv_store_eval #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_eval (
         .valid    (req_valid[i]),
         .write    (req_write[i]),
         .locked   (req_locked[i]),
         .uncache  (req_uncache[i]),
         .addr     (req_addr[i*ADDR_W +: ADDR_W]),
         .cur_flag (resv_flag[i]),
         .cur_addr (resv_addr[i*ADDR_W +: ADDR_W]),
         .is_store (is_store),
         .commit   (commit[i]),
         .sc_fail  (sc_fail),
         .cnt_clr  (cnt_clr),
         .load_set (load_set),
         .code     (code)
      );

      resv_snoop #(.NUM_CTX(NUM_CTX), .TAG_W(TAG_W)) u_snoop (
         .commit     (commit),
         .commit_tag (commit_tag),
         .own_tag    (resv_addr[i*ADDR_W+GRAN_BITS +: TAG_W]),
         .load_tag   (req_addr[i*ADDR_W+GRAN_BITS +: TAG_W]),
         .hit_own    (hit_own),
         .hit_load   (hit_load)
      );

      resv_slot #(.ADDR_W(ADDR_W), .WARN_PERIOD(WARN_PERIOD)) u_slot (
         .clk          (clk),
         .rst          (rst),
         .load_set     (load_set),
         .load_blocked (hit_load),
         .load_addr    (req_addr[i*ADDR_W +: ADDR_W]),
         .clear_hit    (hit_own),
         .is_store     (is_store),
         .commit       (commit[i]),
         .sc_fail      (sc_fail),
         .cnt_clr      (cnt_clr),
         .code         (code),
         .flag         (resv_flag[i]),
         .addr         (resv_addr[i*ADDR_W +: ADDR_W]),
         .rsp_valid    (rsp_valid[i]),
         .rsp_code     (rsp_code[2*i +: 2]),
         .rsp_wr_en    (rsp_wr_en[i]),
         .warn         (fail_warn[i])
      );
   end
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
   parameter int NUM_CTX     = 4,
   parameter int ADDR_W      = 32,
   parameter int GRAN_BITS   = 4,
   parameter int WARN_PERIOD = 100000
) (
   input logic                      clk,
   input logic                      rst,
   input logic [NUM_CTX-1:0]        req_valid,
   input logic [NUM_CTX-1:0]        req_write,
   input logic [NUM_CTX-1:0]        req_locked,
   input logic [NUM_CTX-1:0]        req_uncache,
   input logic [NUM_CTX*ADDR_W-1:0] req_addr,
   input logic [NUM_CTX-1:0]        rsp_valid,
   input logic [2*NUM_CTX-1:0]      rsp_code,
   input logic [NUM_CTX-1:0]        rsp_wr_en,
   input logic [NUM_CTX-1:0]        fail_warn,
   input logic [NUM_CTX-1:0]        resv_flag,
   input logic [NUM_CTX*ADDR_W-1:0] resv_addr
);
   localparam int TAG_W = ADDR_W - GRAN_BITS;

   logic any_store;
   assign any_store = |(req_valid & req_write);

   for (genvar i = 0; i < NUM_CTX; i++) begin : g_i
      AST_LOAD_RESERVES: assert property (@(posedge clk) disable iff (rst)
         (req_valid[i] && !req_write[i] && req_locked[i] && !any_store)
         |=> (resv_flag[i] && resv_addr[i*ADDR_W +: ADDR_W] == $past(req_addr[i*ADDR_W +: ADDR_W]))); // R1

      AST_NO_RESV_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
         (req_valid[i] && req_write[i] && req_locked[i] && !req_uncache[i] && !resv_flag[i])
         |=> (rsp_code[2*i +: 2] == 2'd0 && !rsp_wr_en[i])); // R3

      AST_UNCACHED_WRITES: assert property (@(posedge clk) disable iff (rst)
         (req_valid[i] && req_write[i] && req_locked[i] && req_uncache[i])
         |=> (rsp_code[2*i +: 2] == 2'd2 && rsp_wr_en[i])); // R5

      AST_STORE_RESPONDS: assert property (@(posedge clk) disable iff (rst)
         (req_valid[i] && req_write[i]) |=> rsp_valid[i]); // R9

      AST_LOAD_SILENT: assert property (@(posedge clk) disable iff (rst)
         !(req_valid[i] && req_write[i]) |=> !rsp_valid[i]); // R9

      AST_WARN_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
         fail_warn[i] |-> (rsp_valid[i] && rsp_code[2*i +: 2] == 2'd0)); // R8

      for (genvar k = 0; k < NUM_CTX; k++) begin : g_k
         if (k != i) begin : g_pair
            AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
               (req_valid[k] && req_write[k] && !req_locked[k] && resv_flag[i]
                && req_addr[k*ADDR_W+GRAN_BITS +: TAG_W] == resv_addr[i*ADDR_W+GRAN_BITS +: TAG_W]
                && !(req_valid[i] && !req_write[i] && req_locked[i]))
               |=> !resv_flag[i]); // R6

            AST_STORE_BEATS_LOAD: assert property (@(posedge clk) disable iff (rst)
               (req_valid[k] && req_write[k] && !req_locked[k]
                && req_valid[i] && !req_write[i] && req_locked[i]
                && req_addr[k*ADDR_W+GRAN_BITS +: TAG_W] == req_addr[i*ADDR_W+GRAN_BITS +: TAG_W])
               |=> !resv_flag[i]); // R7
         end
      end
   end
endmodule

bind resv_monitor resv_monitor_chk #(
   .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .WARN_PERIOD(WARN_PERIOD)
) u_chk (
   .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
   .req_locked(req_locked), .req_uncache(req_uncache), .req_addr(req_addr),
   .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_wr_en(rsp_wr_en),
   .fail_warn(fail_warn), .resv_flag(resv_flag), .resv_addr(resv_addr)
);

// File: tb/sim_resv_monitor.sv
`timescale 1ns/1ps
module sim_resv_monitor;
   localparam int N  = 2;
   localparam int AW = 16;
   localparam int WP = 3;

   // request encodings {valid, write, locked, uncache}
   localparam logic [3:0] IDL = 4'b0000, LL = 4'b1010, SC = 4'b1110,
                          SCU = 4'b1111, ST = 4'b1100;
   // expected {rsp_valid, code[1:0], wr_en, warn}
   localparam logic [4:0] NON = 5'b00000, FL = 5'b10000, PS = 5'b10110,
                          UC = 5'b11010, FLW = 5'b10001;

   typedef struct packed {
      logic [3:0]  c0;
      logic [15:0] a0;
      logic [3:0]  c1;
      logic [15:0] a1;
      logic [4:0]  e0;
      logic [4:0]  e1;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{SC,  16'h0100, IDL, 16'h0000, FL,  NON, 4'd3},  // R3 no reservation
      '{LL,  16'h0100, LL,  16'h0200, NON, NON, 4'd9},  // R1 R9 loads silent
      '{SC,  16'h010C, IDL, 16'h0000, PS,  NON, 4'd2},  // R2 same granule
      '{SC,  16'h0100, IDL, 16'h0000, FL,  NON, 4'd6},  // R6 own commit cleared it
      '{ST,  16'h0204, IDL, 16'h0000, PS,  NON, 4'd6},  // R6 plain store
      '{IDL, 16'h0000, SC,  16'h0200, NON, FL,  4'd6},  // R6 cross clear
      '{LL,  16'h0300, LL,  16'h0310, NON, NON, 4'd1},  // R1
      '{SC,  16'h0310, SC,  16'h031F, FL,  PS,  4'd3},  // R3 granule differs
      '{SC,  16'h0300, IDL, 16'h0000, FLW, NON, 4'd4},  // R4 fail cleared, R8 3rd run
      '{SCU, 16'h0500, IDL, 16'h0000, UC,  NON, 4'd5},  // R5
      '{LL,  16'h0600, ST,  16'h0604, NON, PS,  4'd7},  // R7
      '{SC,  16'h0600, IDL, 16'h0000, FL,  NON, 4'd7},  // R7 load lost
      '{LL,  16'h0700, ST,  16'h0800, NON, PS,  4'd1},  // R1 other granule
      '{SC,  16'h0700, IDL, 16'h0000, PS,  NON, 4'd2},  // R2
      '{LL,  16'h0900, LL,  16'h0900, NON, NON, 4'd1},  // R1
      '{SC,  16'h0900, IDL, 16'h0000, PS,  NON, 4'd2},  // R2
      '{IDL, 16'h0000, SC,  16'h0900, NON, FL,  4'd6}   // R6 cleared by conditional
   };

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [N-1:0]      req_valid = '0, req_write = '0, req_locked = '0, req_uncache = '0;
   logic [N*AW-1:0]   req_addr = '0;
   logic [N-1:0]      rsp_valid, rsp_wr_en, fail_warn;
   logic [2*N-1:0]    rsp_code;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   resv_monitor #(.NUM_CTX(N), .ADDR_W(AW), .GRAN_BITS(4), .WARN_PERIOD(WP)) u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_locked(req_locked), .req_uncache(req_uncache), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_wr_en(rsp_wr_en),
      .fail_warn(fail_warn)
   );

   function automatic logic [4:0] obs(input int c);
      return {rsp_valid[c], rsp_code[2*c +: 2], rsp_wr_en[c], fail_warn[c]};
   endfunction

   task automatic check_ctx(input int c, input logic [4:0] exp, input int rq, input string what);
      checks++;
      if (obs(c) !== exp) begin
         errors++;
         $display("FAIL R%0d %s ctx%0d: got %b expected %b", rq, what, c, obs(c), exp);
      end
   endtask

   task automatic drive(input logic [3:0] c0, input logic [15:0] a0,
                        input logic [3:0] c1, input logic [15:0] a1);
      {req_valid[0], req_write[0], req_locked[0], req_uncache[0]} = c0;
      {req_valid[1], req_write[1], req_locked[1], req_uncache[1]} = c1;
      req_addr = {a1, a0};
   endtask

   // drive at a falling edge, check the response one rising edge later
   task automatic step(input logic [3:0] c0, input logic [15:0] a0, input logic [4:0] e0,
                       input logic [3:0] c1, input logic [15:0] a1, input logic [4:0] e1,
                       input int rq, input string what);
      drive(c0, a0, c1, a1);
      @(negedge clk);
      check_ctx(0, e0, rq, what);
      check_ctx(1, e1, rq, what);
   endtask

   task automatic do_reset();
      drive(IDL, 16'h0, IDL, 16'h0);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_ctx(0, NON, 10, "outputs in reset");  // R10
      check_ctx(1, NON, 10, "outputs in reset");  // R10
      rst = 1'b0;

      for (int v = 0; v < NV; v++)
         step(VECS[v].c0, VECS[v].a0, VECS[v].e0, VECS[v].c1, VECS[v].a1, VECS[v].e1,
              int'(VECS[v].rq), $sformatf("vector %0d", v));

      // R10: reservation and failure run lost on reset (ctx1 run is 1, make it 2)
      step(LL,  16'h0A00, NON, SC,  16'h0A00, FL,  8, "pre-reset");
      do_reset();
      @(negedge clk);
      check_ctx(0, NON, 10, "idle after reset");
      check_ctx(1, NON, 10, "idle after reset");
      step(SC,  16'h0A00, FL,  SC,  16'h0B00, FL,  10, "reservation gone, run 1");
      step(IDL, 16'h0000, NON, SC,  16'h0B00, FL,  10, "run 2 no warn");
      step(IDL, 16'h0000, NON, SC,  16'h0B00, FLW, 8,  "run 3 warns");
      // R8: next multiple
      step(IDL, 16'h0000, NON, SC,  16'h0B00, FL,  8,  "run 4");
      step(IDL, 16'h0000, NON, SC,  16'h0B00, FL,  8,  "run 5");
      step(IDL, 16'h0000, NON, SC,  16'h0B00, FLW, 8,  "run 6 warns");
      // R8: a pass restarts the run
      step(IDL, 16'h0000, NON, SC,  16'h0B00, FL,  8,  "run 1 again");
      step(IDL, 16'h0000, NON, LL,  16'h0C00, NON, 1,  "reserve");
      step(IDL, 16'h0000, NON, SC,  16'h0C04, PS,  2,  "pass restarts run");
      step(IDL, 16'h0000, NON, SC,  16'h0C00, FL,  8,  "after pass run 1");
      step(IDL, 16'h0000, NON, SC,  16'h0C00, FL,  8,  "after pass run 2");
      // R5: uncacheable store restarts the run, so the third fail is quiet
      step(IDL, 16'h0000, NON, SCU, 16'h0C00, UC,  5,  "uncached restarts run");
      step(IDL, 16'h0000, NON, SC,  16'h0C00, FL,  5,  "after uncached run 1");
      // R6: plain store to a granule boundary neighbour leaves a reservation
      step(LL,  16'h0D10, NON, ST,  16'h0D0F, PS,  6,  "neighbour store");
      step(SC,  16'h0D1F, PS,  IDL, 16'h0000, NON, 6,  "reservation kept");
      drive(IDL, 16'h0, IDL, 16'h0);
      @(negedge clk);
      check_ctx(0, NON, 9, "idle no response");
      check_ctx(1, NON, 9, "idle no response");
      done = 1'b1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (5000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule